// File: doc/BRIEF.md
# Fractional baud clock-enable generator

This block derives the timing enables for a serial transmitter and receiver from one free-running clock. It produces no new clock. It emits single-cycle enables that the serial logic uses to qualify its registers. Two stages work in series. A fractional stage withholds selected clock cycles so that its pass rate is the clock rate divided by (1 + MULT/256). An integer stage then divides the passed cycles by (DIV + 1). That gives the sampling rate, which is sixteen times the bit rate in asynchronous mode. In synchronous mode it gives the bit rate directly.

A phase accumulator controls the fractional stage. Every passed cycle adds MULT into an 8-bit accumulator. A carry out of the top bit withholds the following cycle. As a result, exactly MULT cycles are withheld in every window of 256 + MULT cycles, and no two withheld cycles are adjacent. All enables are plain control pins with no handshake. Each is high for one clock and is only ever high on a passed cycle. Any change to MULT, DIV or the mode restarts the phase of every counter.

Top module: `baud_tick_gen`

## Requirements
- R1: Starting from reset, every run of 256 + MULT clock cycles contains exactly 256 cycles with `frac_en` high, for MULT in 1..255.
- R2: With MULT = 0, `frac_en` is high on every clock cycle outside reset and restart.
- R3: Cycles with `frac_en` low are spread out: two consecutive cycles never both have `frac_en` low.
- R4: The integer stage raises its output once for every DIV + 1 cycles on which `frac_en` is high. DIV = 0 passes every such cycle through. Over (256 + MULT)·(DIV + 1) cycles from reset there are exactly 256 integer-stage outputs.
- R5: `samp_tick` and `bit_tick` are only ever high on a cycle where `frac_en` is high.
- R6: In asynchronous mode (`sync_mode` = 0), `samp_tick` equals the integer-stage output, and `bit_tick` rises on every 16th `samp_tick`. The first `bit_tick` comes on the 16th `samp_tick` after reset or restart.
- R7: In synchronous mode (`sync_mode` = 1), `bit_tick` equals the integer-stage output and `samp_tick` stays low.
- R8: In the cycle after `frac_mult`, `int_div` or `sync_mode` changes, all enables are low. The accumulator and the counters are cleared at the next edge, so the new ratio then behaves exactly as it would after reset.
- R9: While `rst` (synchronous, active high) is high, all three enables are low. At the first edge with `rst` high, the accumulator and the counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_mult | input | 8 | Fractional multiplier MULT; 0 turns fractional division off |
| int_div | input | 16 | Integer divisor DIV; divide ratio is DIV + 1 |
| sync_mode | input | 1 | 0 = asynchronous (16x sampling), 1 = synchronous (1x) |
| frac_en | output | 1 | High on each cycle the fractional stage passes |
| samp_tick | output | 1 | Sampling enable at 16x bit rate (asynchronous mode only) |
| bit_tick | output | 1 | Bit-rate enable |

## Verification
The bench counts enables over whole ratio periods for several MULT/DIV pairs, including MULT = 0, MULT = 1, MULT = 255 and DIV = 0. An accumulator that dropped its carry, or withheld a cycle at the wrong point, would shift those counts by one or more. Throughout each period the bench watches for two withheld cycles in a row, and for any tick that lands on a withheld cycle. An uneven spreader, or an integer stage that ignored qualification, would show up there. The bench also changes the ratio mid-run without a reset. A design that kept its old phase would give a count that does not match the fresh-start value. Finally, a synchronous case catches a mode select that still divides by 16 or still drives the sampling enable.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  localparam int MULT_W  = 8;
  localparam int DIV_W   = 16;
  localparam int OSR     = 16;
  localparam int OSR_W   = (OSR > 1) ? $clog2(OSR) : 1;
endpackage

// File: rtl/frac_rate_stage.sv
`timescale 1ns/1ps
module frac_rate_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] mult,
  output logic         pass_en
);
  logic [W-1:0] acc_q;
  logic         skip_q;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, mult};
  assign pass_en = ~skip_q & ~rst & ~restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_q  <= '0;
      skip_q <= 1'b0;
    end else if (skip_q) begin
      skip_q <= 1'b0;
    end else begin
      acc_q  <= sum[W-1:0];
      skip_q <= sum[W];
    end
  end
endmodule

// File: rtl/int_div_stage.sv
`timescale 1ns/1ps
module int_div_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         en,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit  = (cnt_q == div);
  assign tick = en & hit;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bit_phase_stage.sv
`timescale 1ns/1ps
module bit_phase_stage #(
  parameter int OSR   = 16,
  parameter int OSR_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  input  logic sync_mode,
  output logic samp_tick,
  output logic bit_tick
);
  assign samp_tick = en & ~sync_mode;

  generate
    if (OSR > 1) begin : g_count
      logic [OSR_W-1:0] ph_q;
      logic             last;
      assign last     = (ph_q == OSR_W'(OSR - 1));
      assign bit_tick = sync_mode ? en : (en & last);
      always_ff @(posedge clk) begin
        if (rst || restart || sync_mode) begin
          ph_q <= '0;
        end else if (en) begin
          ph_q <= last ? '0 : ph_q + 1'b1;
        end
      end
    end else begin : g_bypass
      assign bit_tick = en;
    end
  endgenerate
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] frac_mult,
  input  logic [DIV_W-1:0]  int_div,
  input  logic              sync_mode,
  output logic              frac_en,
  output logic              samp_tick,
  output logic              bit_tick
);
  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;
  logic              mode_q;
  logic              restart;
  logic              div_tick;

  assign restart = (frac_mult != mult_q) | (int_div != div_q) | (sync_mode != mode_q);

  always_ff @(posedge clk) begin
    mult_q <= frac_mult;
    div_q  <= int_div;
    mode_q <= sync_mode;
  end

  frac_rate_stage #(.W(MULT_W)) u_frac (
    .clk(clk), .rst(rst), .restart(restart), .mult(frac_mult), .pass_en(frac_en)
  );

  int_div_stage #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .en(frac_en), .div(int_div), .tick(div_tick)
  );

  bit_phase_stage #(.OSR(OSR), .OSR_W(OSR_W)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .en(div_tick), .sync_mode(sync_mode),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );
endmodule

module baud_tick_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] frac_mult,
  input logic [15:0] int_div,
  input logic       sync_mode,
  input logic       frac_en,
  input logic       samp_tick,
  input logic       bit_tick
);
  p_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (!frac_en && $stable(frac_mult) && $stable(int_div) && $stable(sync_mode)) |=>
      (frac_en || frac_mult != $past(frac_mult) || int_div != $past(int_div) ||
       sync_mode != $past(sync_mode)));

  p_mult0_r2: assert property (@(posedge clk) disable iff (rst)
    (frac_mult == 8'd0 && $stable(frac_mult) && $stable(int_div) && $stable(sync_mode)
     && !$past(rst)) |-> frac_en);

  p_samp_qual_r5: assert property (@(posedge clk) disable iff (rst)
    samp_tick |-> frac_en);

  p_bit_qual_r5: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> frac_en);

  p_async_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && bit_tick) |-> samp_tick);

  p_sync_nosamp_r7: assert property (@(posedge clk) disable iff (rst)
    sync_mode |-> !samp_tick);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (frac_mult != $past(frac_mult) || int_div != $past(int_div))) |->
      (!frac_en && !samp_tick && !bit_tick));

  p_reset_r9: assert property (@(posedge clk)
    rst |-> (!frac_en && !samp_tick && !bit_tick));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst(rst), .frac_mult(frac_mult), .int_div(int_div), .sync_mode(sync_mode),
  .frac_en(frac_en), .samp_tick(samp_tick), .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  frac_mult = '0;
  logic [15:0] int_div = '0;
  logic        sync_mode = 1'b0;
  logic        frac_en, samp_tick, bit_tick;

  always #4 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst(rst), .frac_mult(frac_mult), .int_div(int_div), .sync_mode(sync_mode),
    .frac_en(frac_en), .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  typedef struct { int frac; int samp; int bits; string tag; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_fail = 0;
  bit counting = 0, cmp_req = 0, done = 0;
  int c_frac = 0, c_samp = 0, c_bit = 0;
  int gap_viol = 0, qual_viol = 0;
  bit prev_low = 0;

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: counts, spreading checks, and scoreboard comparison
  always @(negedge clk) begin
    if (counting) begin
      c_frac += int'(frac_en);
      c_samp += int'(samp_tick);
      c_bit  += int'(bit_tick);
      if (!frac_en && prev_low) gap_viol++;      // R3
      if ((samp_tick || bit_tick) && !frac_en) qual_viol++;  // R5
      prev_low = !frac_en;
    end else prev_low = 0;
    if (cmp_req) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " frac_en count (R1/R2)"}, c_frac, e.frac);
      check({e.tag, " samp_tick count (R4/R6/R7)"}, c_samp, e.samp);
      check({e.tag, " bit_tick count (R6/R7)"}, c_bit, e.bits);
      c_frac = 0; c_samp = 0; c_bit = 0;
      cmp_req = 0;
    end
  end

  task automatic count_window(int m, int d, bit sm, string tag);
    exp_t e;
    int w;
    w = (256 + m) * (d + 1);
    e.frac = 256 * (d + 1);
    e.samp = sm ? 0 : 256;
    e.bits = sm ? 256 : 16;
    e.tag  = tag;
    exp_q.push_back(e);
    counting = 1;
    repeat (w) @(posedge clk);
    #1 counting = 0;
    cmp_req = 1;
    wait (cmp_req == 0);
  endtask

  task automatic run_case(int m, int d, bit sm, string tag);
    @(posedge clk); #1;
    rst = 1; frac_mult = 8'(m); int_div = 16'(d); sync_mode = sm;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tag, " R9 reset holds enables low"}, int'({frac_en, samp_tick, bit_tick}), 0);
    @(posedge clk); #1 rst = 0;
    count_window(m, d, sm, tag);
  endtask

  initial begin
    run_case(0,   0, 1'b0, "R2 M=0 D=0");
    run_case(1,   0, 1'b0, "R1 M=1 D=0");
    run_case(128, 3, 1'b0, "R4 M=128 D=3");
    run_case(255, 1, 1'b0, "R1 M=255 D=1");
    run_case(77,  2, 1'b1, "R7 sync M=77 D=2");
    // R8: change ratio mid-run without reset
    run_case(128, 3, 1'b0, "R8 pre-change");
    repeat (500) @(posedge clk);
    #1 frac_mult = 8'd64; int_div = 16'd1;
    @(negedge clk);
    check("R8 enables low in change cycle", int'({frac_en, samp_tick, bit_tick}), 0);
    @(posedge clk); #1;
    count_window(64, 1, 1'b0, "R8 post-change M=64 D=1");
    check("R3 no two adjacent withheld cycles", gap_viol, 0);
    check("R5 ticks only on passed cycles", qual_viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule